// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block turns a pixel coordinate into a byte offset inside a render surface. The surface is stored in one of four layouts. A linear surface is a plain row-major array. A micro-tiled surface packs pixels into 32-byte tiles laid end to end along each row. A macro-tiled surface groups rows of 32-byte tiles into 2048-byte tiles. The combined macro-and-micro layout also stores row pairs interleaved inside each 2048-byte tile. A bypass input forces the linear formula. It is meant for surfaces where an external aperture already performs the tile translation.

A request carries the coordinate, the surface pitch in bytes, the pixel size (2 or 4 bytes) and the layout controls. It is accepted through a valid/ready handshake. The offset comes out of a register one cycle after acceptance and is held until the consumer takes it. Because only power-of-two pixel sizes are supported, every division becomes a shift and every remainder becomes a mask. A single shared multiplier forms the row contribution.

Top module: `tile_addr_gen`

## Requirements
- R1: With both tiling inputs low, the offset is x·bpp + y·pitch, where bpp is 4 when bpp4_i is 1 and 2 when bpp4_i is 0.
- R2: With bypass_i high, the linear formula of R1 applies whatever the two tiling inputs are.
- R3: With macro_tile_i and micro_tile_i both high and bypass_i low, let mw = 16/bpp and MW = 128/bpp. The offset is (y>>4)·(pitch/MW)·2048 + ((y mod 16)>>1)·256 + (y mod 2)·16 + (x/MW)·2048 + ((x mod MW)/mw)·32 + (x mod mw)·bpp.
- R4: With only macro_tile_i high, let mw = 32/bpp and MW = 256/bpp. The offset is (y>>3)·(pitch/MW)·2048 + (y mod 8)·256 + (x/MW)·2048 + ((x mod MW)/mw)·32 + (x mod mw)·bpp.
- R5: With only micro_tile_i high, the pitch is rounded up to a multiple of 32, giving tiles per row n = ceil(pitch/32). The offset is y·n·32 + (x/(32/bpp))·32 + (x mod (32/bpp))·bpp.
- R6: A request accepted on a clock edge (req_valid_i and req_ready_o both high) sets out_valid_o and presents its offset after that same edge.
- R7: req_ready_o is high exactly when out_valid_o is low or out_ready_i is high. While out_valid_o is high and out_ready_i is low, offset_o and out_valid_o hold.
- R8: While rst_ni is low, out_valid_o is low and req_ready_o is high.
- R9: The result is reduced modulo 2^24 when the full sum exceeds 24 bits.
- R10: A presented offset taken with out_ready_i high, with no new request accepted on that edge, clears out_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken |
| x_i | input | 12 | Pixel column |
| y_i | input | 12 | Pixel row |
| pitch_i | input | 14 | Surface pitch in bytes |
| bpp4_i | input | 1 | 1: 4 bytes per pixel, 0: 2 bytes per pixel |
| macro_tile_i | input | 1 | Macro tiling enabled |
| micro_tile_i | input | 1 | Micro tiling enabled |
| bypass_i | input | 1 | Force linear addressing |
| out_valid_o | output | 1 | Offset present |
| out_ready_i | input | 1 | Consumer takes the offset |
| offset_o | output | 24 | Byte offset |

## Verification
Directed vectors cover each layout at both pixel sizes. Coordinates are chosen to land on the tile edges: x just below and at a macro-tile width, odd and even rows, and y at row-group borders. These separate a wrong shift amount from a wrong mask. A pitch that is not a multiple of 32 separates the micro-only round-up from truncation. Bypass with both tiling bits set shows that the override takes precedence. Maximum coordinates and pitch exercise the 24-bit wrap. Random vectors mix all layouts with random consumer stalls, which tells correct held data apart from data overwritten under back-pressure.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;
  typedef enum logic [1:0] {
    LAYOUT_LINEAR     = 2'd0,
    LAYOUT_MICRO      = 2'd1,
    LAYOUT_MACRO      = 2'd2,
    LAYOUT_MACRO_MICRO = 2'd3
  } layout_e;

  localparam int unsigned MACRO_TILE_LG = 11; // 2048-byte tile
  localparam int unsigned MICRO_TILE_LG = 5;  // 32-byte tile
endpackage

// File: rtl/tile_mode_decode.sv
module tile_mode_decode
  import tile_addr_pkg::*;
(
  input  logic    bypass_i,
  input  logic    macro_i,
  input  logic    micro_i,
  output layout_e layout_o
);
  always_comb begin
    if (bypass_i)             layout_o = LAYOUT_LINEAR;
    else if (macro_i && micro_i) layout_o = LAYOUT_MACRO_MICRO;
    else if (macro_i)         layout_o = LAYOUT_MACRO;
    else if (micro_i)         layout_o = LAYOUT_MICRO;
    else                      layout_o = LAYOUT_LINEAR;
  end
endmodule

// File: rtl/tile_row_term.sv
// Shared multiplier: row index times row stride, scaled to bytes.
module tile_row_term
  import tile_addr_pkg::*;
#(
  parameter int unsigned YW = 12,
  parameter int unsigned PW = 14,
  parameter int unsigned OW = 24
) (
  input  layout_e       layout_i,
  input  logic          bpp4_i,
  input  logic [YW-1:0] y_i,
  input  logic [PW-1:0] pitch_i,
  output logic [OW-1:0] row_o
);
  localparam int unsigned MW = YW + PW;
  localparam int unsigned SW = MW + MACRO_TILE_LG;

  logic [1:0]    lg;
  logic [YW-1:0] mul_a;
  logic [PW-1:0] mul_b;
  logic [PW:0]   pitch_up;
  logic [3:0]    row_sh;
  logic [MW-1:0] prod;
  logic [SW-1:0] prod_sh;

  assign lg       = bpp4_i ? 2'd2 : 2'd1;
  assign pitch_up = {1'b0, pitch_i} + (PW+1)'(31);

  always_comb begin
    unique case (layout_i)
      LAYOUT_MICRO: begin
        mul_a  = y_i;
        mul_b  = PW'(pitch_up >> MICRO_TILE_LG);
        row_sh = 4'(MICRO_TILE_LG);
      end
      LAYOUT_MACRO: begin
        mul_a  = y_i >> 3;
        mul_b  = pitch_i >> (4'd8 - 4'(lg));
        row_sh = 4'(MACRO_TILE_LG);
      end
      LAYOUT_MACRO_MICRO: begin
        mul_a  = y_i >> 4;
        mul_b  = pitch_i >> (4'd7 - 4'(lg));
        row_sh = 4'(MACRO_TILE_LG);
      end
      default: begin
        mul_a  = y_i;
        mul_b  = pitch_i;
        row_sh = 4'd0;
      end
    endcase
  end

  assign prod    = MW'(mul_a) * MW'(mul_b);
  assign prod_sh = SW'(prod) << row_sh;
  assign row_o   = OW'(prod_sh);
endmodule

// File: rtl/tile_local_term.sv
// Position inside a row of tiles: column tiles, sub-blocks, row interleave.
module tile_local_term
  import tile_addr_pkg::*;
#(
  parameter int unsigned XW = 12,
  parameter int unsigned YW = 12,
  parameter int unsigned OW = 24
) (
  input  layout_e       layout_i,
  input  logic          bpp4_i,
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  output logic [OW-1:0] local_o
);
  logic [1:0]    lg;
  logic [OW-1:0] x_bytes;
  logic [OW-1:0] mm_col, mm_sub, mm_pix, mm_row;
  logic [OW-1:0] ma_col, ma_sub, ma_pix, ma_row;

  assign lg      = bpp4_i ? 2'd2 : 2'd1;
  assign x_bytes = OW'(x_i) << lg;

  // macro plus micro: 128-byte-wide macro rows, 16-byte micro rows, row pairs interleaved
  assign mm_col = OW'(x_i >> (4'd7 - 4'(lg))) << MACRO_TILE_LG;
  assign mm_sub = OW'((x_i >> (4'd4 - 4'(lg))) & XW'(7)) << MICRO_TILE_LG;
  assign mm_pix = OW'(x_i & ((XW'(1) << (4'd4 - 4'(lg))) - XW'(1))) << lg;
  assign mm_row = (OW'(y_i[3:1]) << 8) + (OW'(y_i[0]) << 4);

  // macro only: 256-byte-wide macro rows, 32-byte micro tiles
  assign ma_col = OW'(x_i >> (4'd8 - 4'(lg))) << MACRO_TILE_LG;
  assign ma_sub = OW'((x_i >> (4'd5 - 4'(lg))) & XW'(7)) << MICRO_TILE_LG;
  assign ma_pix = OW'(x_i & ((XW'(1) << (4'd5 - 4'(lg))) - XW'(1))) << lg;
  assign ma_row = OW'(y_i[2:0]) << 8;

  always_comb begin
    unique case (layout_i)
      LAYOUT_MACRO_MICRO: local_o = mm_col + mm_sub + mm_pix + mm_row;
      LAYOUT_MACRO:       local_o = ma_col + ma_sub + ma_pix + ma_row;
      // micro only and linear both reduce to x*bpp along a row
      default:            local_o = x_bytes;
    endcase
  end
endmodule

// File: rtl/tile_out_stage.sv
module tile_out_stage #(
  parameter int unsigned OW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [OW-1:0] in_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [OW-1:0] out_data_o
);
  logic          vld_q;
  logic [OW-1:0] data_q;

  assign in_ready_o  = !vld_q || out_ready_i;
  assign out_valid_o = vld_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (in_valid_i && in_ready_o) begin
      vld_q  <= 1'b1;
      data_q <= in_data_i;
    end else if (out_ready_i) begin
      vld_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tile_addr_pkg::*;
#(
  parameter int unsigned XW = 12,
  parameter int unsigned YW = 12,
  parameter int unsigned PW = 14,
  parameter int unsigned OW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  input  logic [PW-1:0] pitch_i,
  input  logic          bpp4_i,
  input  logic          macro_tile_i,
  input  logic          micro_tile_i,
  input  logic          bypass_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [OW-1:0] offset_o
);
  layout_e       layout;
  logic [OW-1:0] row_term, local_term, offset_d;

  tile_mode_decode i_decode (
    .bypass_i (bypass_i),
    .macro_i  (macro_tile_i),
    .micro_i  (micro_tile_i),
    .layout_o (layout)
  );

  tile_row_term #(.YW(YW), .PW(PW), .OW(OW)) i_row (
    .layout_i (layout),
    .bpp4_i   (bpp4_i),
    .y_i      (y_i),
    .pitch_i  (pitch_i),
    .row_o    (row_term)
  );

  tile_local_term #(.XW(XW), .YW(YW), .OW(OW)) i_local (
    .layout_i (layout),
    .bpp4_i   (bpp4_i),
    .x_i      (x_i),
    .y_i      (y_i),
    .local_o  (local_term)
  );

  assign offset_d = row_term + local_term;

  tile_out_stage #(.OW(OW)) i_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .in_data_i   (offset_d),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (offset_o)
  );
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
  parameter int unsigned XW = 12,
  parameter int unsigned YW = 12,
  parameter int unsigned PW = 14,
  parameter int unsigned OW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [XW-1:0] x_i,
  input logic [YW-1:0] y_i,
  input logic [PW-1:0] pitch_i,
  input logic          bpp4_i,
  input logic          bypass_i,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [OW-1:0] offset_o
);
  logic fire;
  assign fire = req_valid_i && req_ready_o;

  always @(posedge clk_i) begin
    if (!rst_ni) a_r8_reset_idle: assert (!out_valid_o && req_ready_o);
  end

  a_r6_valid_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> out_valid_o);

  a_r7_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(offset_o)));

  a_r7_ready_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> req_ready_o);

  a_r10_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !fire) |=> !out_valid_o);

  a_r2_bypass_linear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && bypass_i) |=> offset_o ==
      OW'(64'($past(y_i)) * 64'($past(pitch_i)) + (64'($past(x_i)) << ($past(bpp4_i) ? 2 : 1))));
endmodule

bind tile_addr_gen tile_addr_gen_chk #(.XW(XW), .YW(YW), .PW(PW), .OW(OW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .x_i         (x_i),
  .y_i         (y_i),
  .pitch_i     (pitch_i),
  .bpp4_i      (bpp4_i),
  .bypass_i    (bypass_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .offset_o    (offset_o)
);

// File: tb/test_tile_addr_gen.sv
module test_tile_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [11:0] x_i = '0;
  logic [11:0] y_i = '0;
  logic [13:0] pitch_i = '0;
  logic        bpp4_i = 1'b0;
  logic        macro_tile_i = 1'b0;
  logic        micro_tile_i = 1'b0;
  logic        bypass_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [23:0] offset_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tile_addr_gen i_tile_addr_gen (.*);

  function automatic logic [23:0] ref_off(longint x, longint y, longint p, longint bpp,
                                          bit ma, bit mi, bit bp);
    longint o, mw, bw, n;
    if (bp || (!ma && !mi)) o = x * bpp + y * p;
    else if (ma && mi) begin
      mw = 16 / bpp; bw = 128 / bpp; n = p / bw;
      o = (y / 16) * n * 2048 + ((y % 16) / 2) * 256 + (y % 2) * 16
        + (x / bw) * 2048 + ((x % bw) / mw) * 32 + (x % mw) * bpp;
    end else if (ma) begin
      mw = 32 / bpp; bw = 256 / bpp; n = p / bw;
      o = (y / 8) * n * 2048 + (y % 8) * 256
        + (x / bw) * 2048 + ((x % bw) / mw) * 32 + (x % mw) * bpp;
    end else begin
      n = (p + 31) / 32; mw = 32 / bpp;
      o = y * n * 32 + (x / mw) * 32 + (x % mw) * bpp;
    end
    return o[23:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(int x, int y, int p, bit b4, bit ma, bit mi, bit bp);
    x_i = 12'(x); y_i = 12'(y); pitch_i = 14'(p);
    bpp4_i = b4; macro_tile_i = ma; micro_tile_i = mi; bypass_i = bp;
  endtask

  // one request with consumer always ready; checks the offset one cycle later
  task automatic apply(string req, int x, int y, int p, bit b4, bit ma, bit mi, bit bp);
    @(negedge clk_i);
    drive(x, y, p, b4, ma, mi, bp);
    req_valid_i = 1'b1;
    check("R7", 32'(req_ready_o), 32'd1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R6", 32'(out_valid_o), 32'd1);
    check(req, 32'(offset_o), 32'(ref_off(x, y, p, b4 ? 4 : 2, ma, mi, bp)));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check("R8", 32'(out_valid_o), 32'd0);
    check("R8", 32'(req_ready_o), 32'd1);
    rst_ni = 1'b1;

    // R1 linear
    apply("R1", 7, 3, 1000, 1'b0, 0, 0, 0);
    apply("R1", 4095, 100, 8192, 1'b1, 0, 0, 0);
    // R2 bypass beats tiling flags
    apply("R2", 37, 19, 640, 1'b1, 1, 1, 1);
    apply("R2", 200, 9, 1280, 1'b0, 1, 0, 1);
    // R3 macro+micro, tile edges
    apply("R3", 31, 17, 4096, 1'b1, 1, 1, 0);
    apply("R3", 32, 16, 4096, 1'b1, 1, 1, 0);
    apply("R3", 63, 15, 2048, 1'b0, 1, 1, 0);
    apply("R3", 64, 33, 2048, 1'b0, 1, 1, 0);
    // R4 macro only
    apply("R4", 63, 7, 4096, 1'b1, 1, 0, 0);
    apply("R4", 64, 8, 4096, 1'b1, 1, 0, 0);
    apply("R4", 127, 23, 2560, 1'b0, 1, 0, 0);
    apply("R4", 128, 9, 2560, 1'b0, 1, 0, 0);
    // R5 micro only, pitch not multiple of 32
    apply("R5", 9, 5, 1000, 1'b1, 0, 1, 0);
    apply("R5", 17, 11, 33, 1'b0, 0, 1, 0);
    // R9 wrap at 24 bits
    apply("R9", 4095, 4095, 16383, 1'b1, 0, 0, 0);
    apply("R9", 4095, 4095, 16383, 1'b1, 0, 1, 0);

    // R10 drain: offset taken, no new request
    @(negedge clk_i);
    check("R10", 32'(out_valid_o), 32'd0);

    // R7 back-pressure
    out_ready_i = 1'b0;
    drive(5, 6, 512, 1'b1, 1, 1, 0);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    check("R7", 32'(req_ready_o), 32'd0);
    drive(300, 40, 1024, 1'b0, 1, 0, 0);
    @(negedge clk_i);
    check("R7", 32'(out_valid_o), 32'd1);
    check("R7", 32'(offset_o), 32'(ref_off(5, 6, 512, 4, 1, 1, 0)));
    out_ready_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R6", 32'(out_valid_o), 32'd1);
    check("R4", 32'(offset_o), 32'(ref_off(300, 40, 1024, 2, 1, 0, 0)));
    @(negedge clk_i);

    // random vectors with random stalls
    for (int i = 0; i < 400; i++) begin
      int x = int'($urandom_range(4095, 0));
      int y = int'($urandom_range(4095, 0));
      int p = int'($urandom_range(16383, 0));
      bit b4 = 1'($urandom);
      bit ma = 1'($urandom);
      bit mi = 1'($urandom);
      bit bp = ($urandom_range(7, 0) == 0);
      int stall = int'($urandom_range(2, 0));
      string r;
      if (bp || (!ma && !mi)) r = bp ? "R2" : "R1";
      else if (ma && mi) r = "R3";
      else if (ma) r = "R4";
      else r = "R5";
      @(negedge clk_i);
      drive(x, y, p, b4, ma, mi, bp);
      req_valid_i = 1'b1;
      out_ready_i = 1'b0;
      @(negedge clk_i);
      req_valid_i = 1'b0;
      for (int s = 0; s < stall; s++) @(negedge clk_i);
      check("R7", 32'(out_valid_o), 32'd1);
      check(r, 32'(offset_o), 32'(ref_off(x, y, p, b4 ? 4 : 2, ma, mi, bp)));
      out_ready_i = 1'b1;
      @(negedge clk_i);
      check("R10", 32'(out_valid_o), 32'd0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule